// File: doc/BRIEF.md
# Context Register Backup Sequencer

This block moves a register file between two context blocks in memory when the processor switches tasks. One start command carries two base addresses, one for the outgoing context and one for the incoming context. The sequencer then visits every general register except register 0. For each one it stores the current value to the outgoing block and loads the replacement from the incoming block. Every memory access is a request held until the memory acknowledges it.

Once started, the backup always runs to the end and cannot be interrupted or restarted. Interrupt acceptance is masked for the whole run. A return-from-exception does not wait: its fetch is released at once while the backup carries on.

The order of the registers adapts to the pipeline. Registers that the pipeline is currently writing are put off until all the others are done. If the pipeline wants a register whose new value has not arrived yet, that access is stalled. A start that arrives during a run is held, together with its addresses, and launches as soon as the current run completes.

Top module: `srb_seq`

## Requirements
- R1: After reset, busy_o, irq_mask_o, mem_req_o and pipe_stall_o are low and start_ready_o is high.
- R2: Each run writes registers 1 to NREG-1 exactly once and register 0 never. Register r receives the data returned for its load, so at the end of a run the register file holds the incoming context.
- R3: For register r, the store to save_base + r*(DATA_W/8) is issued first, with mem_we_o high and the old register value on mem_wdata_o. It is followed directly by the load from load_base + r*(DATA_W/8), with mem_we_o low. A request holds its address and direction until mem_ack_i.
- R4: busy_o rises on the cycle after a start is accepted and falls on the cycle after the last load is acknowledged. irq_mask_o is high exactly while busy_o is high.
- R5: irq_take_o equals irq_req_i while idle and is low for the whole run.
- R6: rfe_fetch_o follows rfe_i in the same cycle whether or not a run is active, and the run's access sequence is unchanged by it.
- R7: A start accepted while busy is held: start_ready_o goes low the next cycle, the running backup is not disturbed, and the held run begins with its own addresses one idle cycle after the first run ends (busy_o low for exactly one cycle).
- R8: The next register chosen is the lowest-numbered unfinished register whose bit in pipe_wr_busy_i is low. If every unfinished register is flagged, the lowest-numbered unfinished register is chosen.
- R9: pipe_stall_o is high exactly when busy_o and pipe_use_i are high and register pipe_use_idx_i (not 0) has not yet been loaded in the current run. This includes the register whose load is in flight.
- R10: A start with start_ready_o high while idle is accepted, with no effect from start_i while start_ready_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| start_save_base_i | input | ADDR_W | Outgoing context base address |
| start_load_base_i | input | ADDR_W | Incoming context base address |
| start_ready_o | output | 1 | No start is held pending |
| busy_o | output | 1 | Backup in progress |
| irq_mask_o | output | 1 | Interrupt acceptance masked |
| irq_req_i | input | 1 | Interrupt request |
| irq_take_o | output | 1 | Interrupt accepted |
| rfe_i | input | 1 | Return-from-exception issued |
| rfe_fetch_o | output | 1 | Return fetch released |
| pipe_wr_busy_i | input | NREG | Registers with a pipeline write in flight |
| pipe_use_i | input | 1 | Pipeline register access |
| pipe_use_idx_i | input | log2(NREG) | Register the pipeline accesses |
| pipe_stall_o | output | 1 | Pipeline access must wait |
| rf_rd_idx_o | output | log2(NREG) | Register file read index |
| rf_rd_data_i | input | DATA_W | Register file read data |
| rf_wr_en_o | output | 1 | Register file write enable |
| rf_wr_idx_o | output | log2(NREG) | Register file write index |
| rf_wr_data_o | output | DATA_W | Register file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a store |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Store data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | DATA_W | Load data, valid with acknowledge |

## Verification
A corrupted finished-register mask shows up on the next memory request: the store address goes to a register out of order, repeats a register, or skips one. It also shows on pipe_stall_o in the very cycle the mask is wrong. A wrong state or a broken last-register detection shows up on busy_o and irq_mask_o one cycle after the final acknowledge, and as a missing or extra access. A lost pending start is seen when busy_o stays low two cycles after a run ends.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STORE = 2'd1,
    ST_LOAD  = 2'd2
  } srb_state_e;
endpackage

// File: rtl/srb_pick.sv
// Selects next register: lowest unfinished and not pipeline-busy, else lowest unfinished.
module srb_pick #(
  parameter int NREG  = 64,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  done_i,
  input  logic [NREG-1:0]  defer_i,
  output logic [IDX_W-1:0] sel_o,
  output logic             any_o
);
  logic [IDX_W-1:0] sel_free, sel_any;
  logic             has_free;

  always_comb begin
    sel_free = '0;
    sel_any  = '0;
    has_free = 1'b0;
    any_o    = 1'b0;
    for (int i = NREG-1; i >= 1; i--) begin
      if (!done_i[i]) begin
        sel_any = IDX_W'(i);
        any_o   = 1'b1;
        if (!defer_i[i]) begin
          sel_free = IDX_W'(i);
          has_free = 1'b1;
        end
      end
    end
    sel_o = has_free ? sel_free : sel_any;
  end
endmodule

// File: rtl/srb_pend.sv
// One-deep holder for a start that arrives during a run.
module srb_pend #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] save_i,
  input  logic [ADDR_W-1:0] load_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] save_o,
  output logic [ADDR_W-1:0] load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      save_o  <= '0;
      load_o  <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      save_o  <= save_i;
      load_o  <= load_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/srb_addr.sv
module srb_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int BYTES  = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = base_i + (ADDR_W'(idx_i) * ADDR_W'(BYTES));
endmodule

// File: rtl/srb_seq.sv
module srb_seq #(
  parameter int NREG   = 64,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_save_base_i,
  input  logic [ADDR_W-1:0] start_load_base_i,
  output logic              start_ready_o,
  output logic              busy_o,
  output logic              irq_mask_o,
  input  logic              irq_req_i,
  output logic              irq_take_o,
  input  logic              rfe_i,
  output logic              rfe_fetch_o,
  input  logic [NREG-1:0]   pipe_wr_busy_i,
  input  logic              pipe_use_i,
  input  logic [IDX_W-1:0]  pipe_use_idx_i,
  output logic              pipe_stall_o,
  output logic [IDX_W-1:0]  rf_rd_idx_o,
  input  logic [DATA_W-1:0] rf_rd_data_i,
  output logic              rf_wr_en_o,
  output logic [IDX_W-1:0]  rf_wr_idx_o,
  output logic [DATA_W-1:0] rf_wr_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import srb_pkg::*;

  srb_state_e        state_q, state_d;
  logic [IDX_W-1:0]  cur_q;
  logic [NREG-1:0]   done_q, done_d;
  logic [ADDR_W-1:0] save_q, load_q;
  logic [ADDR_W-1:0] save_addr, load_addr;
  logic [ADDR_W-1:0] launch_save, launch_load;
  logic [IDX_W-1:0]  pick_sel;
  logic              pick_any;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_save, pend_load;
  logic              in_idle, launch, pend_set, load_done;
  logic [NREG-1:0]   cur_oh;

  assign in_idle   = (state_q == ST_IDLE);
  assign pend_set  = start_i && !pend_valid && !in_idle;
  assign launch    = in_idle && (pend_valid || start_i);
  assign load_done = (state_q == ST_LOAD) && mem_ack_i;
  assign cur_oh    = NREG'(1) << cur_q;

  assign launch_save = pend_valid ? pend_save : start_save_base_i;
  assign launch_load = pend_valid ? pend_load : start_load_base_i;

  srb_pend #(.ADDR_W(ADDR_W)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (pend_set),
    .take_i  (in_idle),
    .save_i  (start_save_base_i),
    .load_i  (start_load_base_i),
    .valid_o (pend_valid),
    .save_o  (pend_save),
    .load_o  (pend_load)
  );

  // mask after this cycle; register 0 is never visited
  always_comb begin
    done_d = done_q;
    if (launch)         done_d = {{(NREG-1){1'b0}}, 1'b1};
    else if (load_done) done_d = done_q | cur_oh;
  end

  srb_pick #(.NREG(NREG)) u_pick (
    .done_i  (done_d),
    .defer_i (pipe_wr_busy_i),
    .sel_o   (pick_sel),
    .any_o   (pick_any)
  );

  srb_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BYTES(BYTES)) u_save_addr (
    .base_i (save_q),
    .idx_i  (cur_q),
    .addr_o (save_addr)
  );

  srb_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BYTES(BYTES)) u_load_addr (
    .base_i (load_q),
    .idx_i  (cur_q),
    .addr_o (load_addr)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (launch) state_d = ST_STORE;
      ST_STORE: if (mem_ack_i) state_d = ST_LOAD;
      ST_LOAD:  if (mem_ack_i) state_d = pick_any ? ST_STORE : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      done_q  <= '1;
      save_q  <= '0;
      load_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (launch) begin
        save_q <= launch_save;
        load_q <= launch_load;
      end
      if (launch || (load_done && pick_any)) cur_q <= pick_sel;
    end
  end

  assign start_ready_o = !pend_valid;
  assign busy_o        = !in_idle;
  assign irq_mask_o    = busy_o;
  assign irq_take_o    = irq_req_i && !busy_o;
  assign rfe_fetch_o   = rfe_i;
  assign pipe_stall_o  = busy_o && pipe_use_i && !done_q[pipe_use_idx_i];

  assign mem_req_o   = !in_idle;
  assign mem_we_o    = (state_q == ST_STORE);
  assign mem_addr_o  = mem_we_o ? save_addr : load_addr;
  assign mem_wdata_o = rf_rd_data_i;
  assign rf_rd_idx_o = cur_q;

  assign rf_wr_en_o   = load_done;
  assign rf_wr_idx_o  = cur_q;
  assign rf_wr_data_o = mem_rdata_i;
endmodule

// File: rtl/srb_seq_chk.sv
module srb_seq_chk #(
  parameter int NREG   = 64,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              start_ready_o,
  input logic              busy_o,
  input logic              irq_take_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              rf_wr_en_o,
  input logic [IDX_W-1:0]  rf_wr_idx_o,
  input logic              pipe_stall_o
);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R3
  store_then_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> mem_req_o && !mem_we_o);
  // R2
  rf_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_en_o |-> mem_req_o && !mem_we_o && mem_ack_i && (rf_wr_idx_o != '0));
  // R5
  irq_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !irq_take_o);
  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && start_ready_o |=> busy_o);
  // R7
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && start_ready_o |=> !start_ready_o);
  // R9
  stall_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_stall_o |-> busy_o);
endmodule

bind srb_seq srb_seq_chk #(.NREG(NREG), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .start_ready_o (start_ready_o),
  .busy_o        (busy_o),
  .irq_take_o    (irq_take_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .mem_ack_i     (mem_ack_i),
  .rf_wr_en_o    (rf_wr_en_o),
  .rf_wr_idx_o   (rf_wr_idx_o),
  .pipe_stall_o  (pipe_stall_o)
);

// File: tb/srb_seq_tb.sv
module srb_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG   = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 3;
  localparam int BYTES  = 2;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] save_b = '0, load_b = '0;
  logic start_ready_o, busy_o, irq_mask_o, irq_take_o, rfe_fetch_o, pipe_stall_o;
  logic irq_req_i = 1'b1, rfe_i = 1'b0, pipe_use_i = 1'b1;
  logic [NREG-1:0] pipe_wr_busy_i = '0;
  logic [IDX_W-1:0] pipe_use_idx_i = '0;
  logic [IDX_W-1:0] rf_rd_idx_o, rf_wr_idx_o;
  logic [DATA_W-1:0] rf_rd_data_i, rf_wr_data_o, mem_wdata_o;
  logic rf_wr_en_o, mem_req_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic mem_ack_i = 1'b0;
  logic [DATA_W-1:0] mem_rdata_i = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  srb_seq #(.NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .start_save_base_i(save_b), .start_load_base_i(load_b),
    .start_ready_o(start_ready_o), .busy_o(busy_o), .irq_mask_o(irq_mask_o),
    .irq_req_i(irq_req_i), .irq_take_o(irq_take_o), .rfe_i(rfe_i),
    .rfe_fetch_o(rfe_fetch_o), .pipe_wr_busy_i(pipe_wr_busy_i),
    .pipe_use_i(pipe_use_i), .pipe_use_idx_i(pipe_use_idx_i),
    .pipe_stall_o(pipe_stall_o), .rf_rd_idx_o(rf_rd_idx_o),
    .rf_rd_data_i(rf_rd_data_i), .rf_wr_en_o(rf_wr_en_o),
    .rf_wr_idx_o(rf_wr_idx_o), .rf_wr_data_o(rf_wr_data_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  // register file environment
  logic [DATA_W-1:0] rf [NREG];
  logic [DATA_W-1:0] rf_m [NREG];
  assign rf_rd_data_i = rf[rf_rd_idx_o];
  always @(posedge clk_i) if (rf_wr_en_o) rf[rf_wr_idx_o] <= rf_wr_data_o;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected transaction queue
  logic            q_we   [256];
  logic [IDX_W-1:0] q_reg [256];
  logic [ADDR_W-1:0] q_addr [256];
  int head = 0, tail = 0, runs_q = 0, ack_dly = 0;

  task automatic start_run(input logic [ADDR_W-1:0] sb, input logic [ADDR_W-1:0] lb,
                           input logic [NREG-1:0] mask);
    bit was_busy;
    @(negedge clk_i);
    while (!start_ready_o) @(negedge clk_i);
    was_busy = busy_o;
    pipe_wr_busy_i = mask;
    save_b = sb; load_b = lb; start_i = 1'b1;
    for (int pass = 0; pass < 2; pass++)
      for (int r = 1; r < NREG; r++)
        if (mask[r] == pass[0]) begin
          q_we[tail] = 1'b1; q_reg[tail] = IDX_W'(r); q_addr[tail] = sb + ADDR_W'(r*BYTES); tail++;
          q_we[tail] = 1'b0; q_reg[tail] = IDX_W'(r); q_addr[tail] = lb + ADDR_W'(r*BYTES); tail++;
        end
    runs_q++;
    @(negedge clk_i);
    start_i = 1'b0;
    if (!was_busy) chk(busy_o == 1'b1, "R10 start accepted", busy_o, 1);
    else           chk(start_ready_o == 1'b0, "R7 start held", start_ready_o, 0);
  endtask

  // monitor and memory responder
  logic busy_prev = 1'b0, ack_q = 1'b0;
  logic [NREG-1:0] restored = '1;
  int wait_c = 0, loads_run = 0, cyc = 0;
  bit exp_idle = 0, exp_rise = 0;
  always @(negedge clk_i) begin
    logic ack_n;
    if (rst_ni) begin
      cyc++;
      if (busy_o && !busy_prev) restored = {{(NREG-1){1'b0}}, 1'b1};
      chk(irq_take_o == (irq_req_i && !busy_o), "R5 irq take", irq_take_o, irq_req_i && !busy_o);
      chk(irq_mask_o == busy_o, "R4 mask tracks busy", irq_mask_o, busy_o);
      chk(rfe_fetch_o == rfe_i, "R6 rfe pass", rfe_fetch_o, rfe_i);
      chk(pipe_stall_o == (busy_o && pipe_use_i && !restored[pipe_use_idx_i]),
          "R9 stall", pipe_stall_o, busy_o && pipe_use_i && !restored[pipe_use_idx_i]);
      if (exp_rise) begin
        chk(busy_o == 1'b1, "R7 held run starts", busy_o, 1);
        exp_rise = 0;
      end
      if (exp_idle) begin
        chk(busy_o == 1'b0, "R4 busy falls", busy_o, 0);
        for (int r = 0; r < NREG; r++) chk(rf[r] == rf_m[r], "R2 rf content", rf[r], rf_m[r]);
        exp_idle = 0;
        exp_rise = (runs_q > 0);
      end
      busy_prev = busy_o;
      ack_n = 1'b0;
      if (ack_q) wait_c = 0;
      else if (mem_req_o) begin
        if (wait_c >= ack_dly) ack_n = 1'b1;
        else wait_c++;
      end
      if (ack_n) begin
        if (head >= tail) chk(0, "R2 extra access", mem_addr_o, 0);
        else begin
          chk(mem_we_o == q_we[head], "R3 direction", mem_we_o, q_we[head]);
          chk(mem_addr_o == q_addr[head], "R8 R3 address/order", mem_addr_o, q_addr[head]);
          if (q_we[head])
            chk(mem_wdata_o == rf_m[q_reg[head]], "R3 old value", mem_wdata_o, rf_m[q_reg[head]]);
          else begin
            rf_m[q_reg[head]] = q_addr[head] ^ KEY;
            restored[q_reg[head]] = 1'b1;
            loads_run++;
            if (loads_run == NREG-1) begin
              loads_run = 0; runs_q--; exp_idle = 1;
            end
          end
          head++;
        end
      end
      ack_q = ack_n;
      mem_ack_i = ack_n;
      mem_rdata_i = ack_n ? (mem_addr_o ^ KEY) : '0;
      rfe_i = cyc[1];
      irq_req_i = !cyc[2] || cyc[0];
      pipe_use_idx_i = IDX_W'(cyc % NREG);
    end
  end

  task automatic drain();
    @(negedge clk_i);
    while (head != tail || busy_o || runs_q != 0 || exp_idle || exp_rise) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin
      rf[r] = 16'h1000 + DATA_W'(r * 16'h0111);
      rf_m[r] = rf[r];
    end
    #(CLK_PERIOD*2 + 2);
    chk(busy_o == 0 && irq_mask_o == 0 && mem_req_o == 0, "R1 reset outputs", busy_o, 0);
    chk(start_ready_o == 1 && pipe_stall_o == 0, "R1 reset ready", start_ready_o, 1);
    rst_ni = 1'b1;
    // sweep of masks and acknowledge delays
    for (int m = 0; m < 6; m++) begin
      logic [NREG-1:0] mk;
      case (m)
        0: mk = 8'h00;
        1: mk = 8'h2A;
        2: mk = 8'hFE;
        3: mk = 8'h90;
        4: mk = 8'h0E;
        default: mk = 8'hC0;
      endcase
      ack_dly = m % 3;
      start_run(16'h0100 + 16'(m * 16'h0040), 16'h4000 + 16'(m * 16'h0100), mk);
      drain();
    end
    // R7: back-to-back starts, second held
    ack_dly = 1;
    start_run(16'h2000, 16'h6000, 8'h14);
    start_run(16'h2800, 16'h7000, 8'h14);
    drain();
    ack_dly = 0;
    start_run(16'h3000, 16'h7800, 8'h00);
    start_run(16'h3400, 16'h7C00, 8'h00);
    start_run(16'h3800, 16'h7E00, 8'h00);
    drain();
    chk(head == tail, "R2 all accesses seen", head, tail);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule